// File: doc/BRIEF.md
# Least-Attained-Service Thread Ranker

This block orders the hardware threads that share a memory controller by how much memory service each has received recently, and uses that order to choose the next request from a small request buffer. Time is divided into fixed-length quanta whose length comes in on an input port. During a quantum, one saturating counter per thread counts the cycles in which that thread was being served. At the last cycle of a quantum, each counter is blended into a smoothed per-thread total with a fixed weight `ALPHA/16`, and the counter is cleared. All threads are then re-ranked so that the thread with the smallest total comes first. That ranking stays fixed for the whole next quantum.

Requests enter the buffer with a thread, a bank, a row and an arrival timestamp. Every cycle the block offers one selected request. A request that has waited at least `STARVE_AGE` time units always wins. After that come requests from the better-ranked thread, then requests that hit the bank's open row, then the oldest request. Asserting `sel_take` removes the offered request at the next clock edge.

Top module: `las_ranker`

## Requirements
- R1: After reset every smoothed total is zero, thread t has rank value t (0 is best), the buffer is empty and `sel_valid` is 0.
- R2: A quantum spans exactly `quantum_len` rising edges counted from reset release. A service pulse on any of those edges, including the last one, counts toward that quantum.
- R3: At the quantum's last edge, each thread's total becomes (ALPHA*old_total + (16-ALPHA)*attained) >> 4, where attained is the pulse count of that quantum. The attained count then restarts from zero.
- R4: Field t of `rank_o` (bits [t*TIDW +: TIDW]) holds thread t's rank value. A lower total gives a smaller rank value. Equal totals are ordered by the lower thread ID first. The values always form a permutation of 0..NTHR-1.
- R5: `rank_o` changes only on a quantum's last edge. The new ranks are visible right after that edge, and the old ranks are visible until then.
- R6: A buffered request with (cur_time - arrival) mod 2^TSW >= STARVE_AGE is selected ahead of any request that has not reached that age.
- R7: Among requests of equal starvation status, a request from a thread with a smaller rank value is selected first.
- R8: After that, a row hit is preferred. A row hit means that bit b of `open_valid` is set and field b of `open_row` (bits [b*ROWW +: ROWW]) equals the request's row, where b is the request's bank.
- R9: After that, the request with the larger age (cur_time - arrival, modulo 2^TSW) is selected. Any remaining tie goes to the lower buffer slot.
- R10: `sel_take` with `sel_valid` high removes the selected request at the next edge. An enqueue takes the lowest free slot at that edge. An enqueue while all DEPTH slots are full is ignored.
- R11: `sel_valid` is high in every cycle in which the buffer holds a request. The selection outputs follow the current buffer contents, `cur_time` and the open-row inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quantum_len | input | 32 | Quantum length in cycles, at least 1 |
| svc_pulse | input | NTHR | Per-thread service pulse, one count per cycle |
| enq_valid | input | 1 | Enqueue a request this cycle |
| enq_thread | input | TIDW | Thread of the new request |
| enq_bank | input | BKW | Bank of the new request |
| enq_row | input | ROWW | Row of the new request |
| enq_time | input | TSW | Arrival timestamp of the new request |
| cur_time | input | TSW | Current timestamp used to compute age |
| open_valid | input | NBANK | Per-bank flag that a row is open |
| open_row | input | NBANK*ROWW | Per-bank open row, field b for bank b |
| sel_take | input | 1 | Remove the offered request |
| sel_valid | output | 1 | A request is offered |
| sel_thread | output | TIDW | Thread of the offered request |
| sel_bank | output | BKW | Bank of the offered request |
| sel_row | output | ROWW | Row of the offered request |
| rank_o | output | NTHR*TIDW | Per-thread rank values, field t for thread t |

## Verification
Ranks are due on the falling edge right after the `quantum_len`-th rising edge of a quantum. The bench drives service pulses one falling edge ahead of each counted edge, and it compares the ranks on the falling edge before that last edge (old values expected) and on the falling edge after it (new values expected). Because selection is combinational, the offered request is compared 2 ns after the falling edge on which `sel_take` goes high, in the same cycle. An enqueue or a removal shows up on the falling edge after the edge that stores it. The full-buffer case is checked by draining the buffer and observing that `sel_valid` drops once the DEPTH stored entries have been taken.

// File: rtl/las_ranker.sv
module las_ranker #(
  parameter int NTHR       = 4,
  parameter int NBANK      = 4,
  parameter int DEPTH      = 8,
  parameter int ROWW       = 10,
  parameter int TSW        = 16,
  parameter int CNTW       = 24,
  parameter int ALPHA      = 12,
  parameter int STARVE_AGE = 1000,
  localparam int TIDW = $clog2(NTHR),
  localparam int BKW  = $clog2(NBANK)
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [31:0]           quantum_len,
  input  logic [NTHR-1:0]       svc_pulse,
  input  logic                  enq_valid,
  input  logic [TIDW-1:0]       enq_thread,
  input  logic [BKW-1:0]        enq_bank,
  input  logic [ROWW-1:0]       enq_row,
  input  logic [TSW-1:0]        enq_time,
  input  logic [TSW-1:0]        cur_time,
  input  logic [NBANK-1:0]      open_valid,
  input  logic [NBANK*ROWW-1:0] open_row,
  input  logic                  sel_take,
  output logic                  sel_valid,
  output logic [TIDW-1:0]       sel_thread,
  output logic [BKW-1:0]        sel_bank,
  output logic [ROWW-1:0]       sel_row,
  output logic [NTHR*TIDW-1:0]  rank_o
);
  localparam int SLW = $clog2(DEPTH);
  localparam int FW  = CNTW + 5;
  localparam int KW  = 2 + TIDW + TSW;

  logic [31:0]     qcnt;
  logic            qend;
  logic [CNTW-1:0] att    [NTHR];
  logic [CNTW-1:0] att_in [NTHR];
  logic [CNTW-1:0] tot    [NTHR];
  logic [CNTW-1:0] tot_nx [NTHR];
  logic [FW-1:0]   mix    [NTHR];
  logic [TIDW-1:0] rank   [NTHR];
  logic [TIDW-1:0] rank_nx[NTHR];

  assign qend = (qcnt >= quantum_len - 32'd1);

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      att_in[t] = (svc_pulse[t] && att[t] != '1) ? att[t] + CNTW'(1) : att[t];
      mix[t]    = FW'(tot[t]) * FW'(ALPHA) + FW'(att_in[t]) * FW'(16 - ALPHA);
      tot_nx[t] = mix[t][CNTW+3:4];
    end
  end

  always_comb begin
    for (int i = 0; i < NTHR; i++) begin
      rank_nx[i] = '0;
      for (int j = 0; j < NTHR; j++)
        if (j != i && (tot_nx[j] < tot_nx[i] || (tot_nx[j] == tot_nx[i] && j < i)))
          rank_nx[i] = rank_nx[i] + TIDW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt <= '0;
      for (int t = 0; t < NTHR; t++) begin
        att[t]  <= '0;
        tot[t]  <= '0;
        rank[t] <= TIDW'(t);
      end
    end else if (qend) begin
      qcnt <= '0;
      for (int t = 0; t < NTHR; t++) begin
        att[t]  <= '0;
        tot[t]  <= tot_nx[t];
        rank[t] <= rank_nx[t];
      end
    end else begin
      qcnt <= qcnt + 32'd1;
      for (int t = 0; t < NTHR; t++) att[t] <= att_in[t];
    end
  end

  for (genvar g = 0; g < NTHR; g++) begin : g_rank
    assign rank_o[g*TIDW +: TIDW] = rank[g];
  end

  logic [ROWW-1:0] orow [NBANK];
  for (genvar g = 0; g < NBANK; g++) begin : g_orow
    assign orow[g] = open_row[g*ROWW +: ROWW];
  end

  logic [DEPTH-1:0] vld;
  logic [TIDW-1:0]  b_thr  [DEPTH];
  logic [BKW-1:0]   b_bank [DEPTH];
  logic [ROWW-1:0]  b_row  [DEPTH];
  logic [TSW-1:0]   b_time [DEPTH];
  logic [TSW-1:0]   age    [DEPTH];
  logic [DEPTH-1:0] starv;
  logic [KW-1:0]    key    [DEPTH];
  logic [KW-1:0]    best;
  logic [SLW-1:0]   fslot, sel_slot;
  logic             ffound;

  always_comb begin
    ffound = 1'b0;
    fslot  = '0;
    for (int s = DEPTH-1; s >= 0; s--)
      if (!vld[s]) begin
        ffound = 1'b1;
        fslot  = SLW'(s);
      end
  end

  always_comb begin
    for (int s = 0; s < DEPTH; s++) begin
      age[s]   = cur_time - b_time[s];
      starv[s] = age[s] >= TSW'(STARVE_AGE);
      key[s]   = {starv[s], ~rank[b_thr[s]],
                  open_valid[b_bank[s]] && orow[b_bank[s]] == b_row[s], age[s]};
    end
  end

  always_comb begin
    sel_valid = 1'b0;
    sel_slot  = '0;
    best      = '0;
    for (int s = 0; s < DEPTH; s++)
      if (vld[s] && (!sel_valid || key[s] > best)) begin
        sel_valid = 1'b1;
        sel_slot  = SLW'(s);
        best      = key[s];
      end
  end

  assign sel_thread = b_thr[sel_slot];
  assign sel_bank   = b_bank[sel_slot];
  assign sel_row    = b_row[sel_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else begin
      if (sel_take && sel_valid) vld[sel_slot] <= 1'b0;
      if (enq_valid && ffound)   vld[fslot]    <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (enq_valid && ffound) begin
      b_thr[fslot]  <= enq_thread;
      b_bank[fslot] <= enq_bank;
      b_row[fslot]  <= enq_row;
      b_time[fslot] <= enq_time;
    end
  end

  logic [NTHR-1:0] rmatch [NTHR];
  always_comb begin
    for (int r = 0; r < NTHR; r++)
      for (int t = 0; t < NTHR; t++)
        rmatch[r][t] = (rank[t] == TIDW'(r));
  end

  // R5
  rank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !qend |=> $stable(rank_o));

  for (genvar r = 0; r < NTHR; r++) begin : g_perm
    // R4
    rank_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rmatch[r]) == 1);
  end

  // R11
  offer_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|vld) |-> sel_valid);

  // R6
  starve_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(starv & vld)) |-> starv[sel_slot]);

  // R10
  take_remove_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_take && sel_valid && !enq_valid) |=> $countones(vld) == $countones($past(vld)) - 1);
endmodule

// File: tb/sim_las_ranker.sv
module sim_las_ranker;
  localparam int NTHR = 4, NBANK = 4, DEPTH = 8, ROWW = 10, TSW = 16, CNTW = 24;
  localparam int ALPHA = 8, STARVE = 64, Q = 20;
  localparam int TIDW = 2, BKW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] quantum_len = 32'(Q);
  logic [NTHR-1:0] svc_pulse = '0;
  logic enq_valid = 1'b0;
  logic [TIDW-1:0] enq_thread = '0;
  logic [BKW-1:0] enq_bank = '0;
  logic [ROWW-1:0] enq_row = '0;
  logic [TSW-1:0] enq_time = '0, cur_time = '0;
  logic [NBANK-1:0] open_valid = '0;
  logic [NBANK*ROWW-1:0] open_row = '0;
  logic sel_take = 1'b0;
  logic sel_valid;
  logic [TIDW-1:0] sel_thread;
  logic [BKW-1:0] sel_bank;
  logic [ROWW-1:0] sel_row;
  logic [NTHR*TIDW-1:0] rank_o;

  las_ranker #(.NTHR(NTHR), .NBANK(NBANK), .DEPTH(DEPTH), .ROWW(ROWW), .TSW(TSW),
               .CNTW(CNTW), .ALPHA(ALPHA), .STARVE_AGE(STARVE)) u0 (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int mtot[NTHR];
  int erank[NTHR];
  int exp_thr[$], exp_row[$];
  string exp_req[$];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rk(int t);
    return int'(rank_o[t*TIDW +: TIDW]);
  endfunction

  task automatic check_ranks(string req);
    for (int t = 0; t < NTHR; t++) chk($sformatf("%s rank T%0d", req, t), rk(t), erank[t]);
  endtask

  task automatic run_q(int a, int b, int c, int d);
    int p[NTHR];
    p = '{a, b, c, d};
    for (int cy = 0; cy < Q; cy++) begin
      for (int t = 0; t < NTHR; t++) svc_pulse[t] = (cy < p[t]);
      if (cy == Q/2) check_ranks("R5 mid");
      if (cy == Q-1) check_ranks("R5 last");
      @(negedge clk);
    end
    svc_pulse = '0;
    for (int t = 0; t < NTHR; t++) mtot[t] = (ALPHA*mtot[t] + (16-ALPHA)*p[t]) >> 4;
    for (int i = 0; i < NTHR; i++) begin
      erank[i] = 0;
      for (int j = 0; j < NTHR; j++)
        if (j != i && (mtot[j] < mtot[i] || (mtot[j] == mtot[i] && j < i))) erank[i]++;
    end
    check_ranks("R2 R3 R4 new");
  endtask

  task automatic enq(int thr, int bank, int row, int tm);
    enq_valid = 1'b1;
    enq_thread = TIDW'(thr);
    enq_bank = BKW'(bank);
    enq_row = ROWW'(row);
    enq_time = TSW'(tm);
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic pick(string req, int thr, int row);
    exp_req.push_back(req);
    exp_thr.push_back(thr);
    exp_row.push_back(row);
    sel_take = 1'b1;
    @(negedge clk);
    sel_take = 1'b0;
  endtask

  always @(negedge clk) begin
    #2;
    if (sel_take && rst_n) begin
      if (exp_req.size() == 0) chk("R10 unexpected take", 1, 0);
      else begin
        string r;
        int et, er;
        r = exp_req.pop_front();
        et = exp_thr.pop_front();
        er = exp_row.pop_front();
        chk({r, " valid"}, int'(sel_valid), 1);
        chk({r, " thread"}, int'(sel_thread), et);
        chk({r, " row"}, int'(sel_row), er);
      end
    end
  end

  initial begin
    #(8*100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NTHR; t++) begin mtot[t] = 0; erank[t] = t; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_ranks("R1 reset");
    chk("R1 reset sel_valid", int'(sel_valid), 0);
    run_q(20, 2, 6, 2);
    run_q(0, 12, 0, 4);
    run_q(0, 0, 0, 1);
    quantum_len = 32'hFFFF_FFFF;

    open_valid = 4'b0001;
    open_row[0 +: ROWW] = ROWW'(5);
    open_row[ROWW +: ROWW] = ROWW'(7);
    cur_time = 16'd100;

    enq(1, 0, 5, 90);
    chk("R11 valid after enqueue", int'(sel_valid), 1);
    enq(0, 2, 9, 95);
    pick("R7 rank over hit", 0, 9);
    pick("R7 remaining", 1, 5);
    chk("R10 empty after takes", int'(sel_valid), 0);

    enq(0, 0, 5, 98);
    enq(0, 2, 9, 50);
    pick("R8 hit over age", 0, 5);
    pick("R8 remaining", 0, 9);

    enq(0, 1, 7, 98);
    enq(0, 2, 8, 90);
    pick("R8 closed bank no hit", 0, 8);
    pick("R8 closed remaining", 0, 7);

    enq(3, 2, 1, 80);
    enq(3, 2, 2, 70);
    pick("R9 oldest", 3, 2);
    pick("R9 remaining", 3, 1);

    enq(2, 0, 5, 99);
    enq(1, 2, 3, 20);
    pick("R6 starved first", 1, 3);
    pick("R6 remaining", 2, 5);

    cur_time = 16'd10;
    enq(2, 2, 6, 5);
    enq(2, 2, 4, 65530);
    pick("R9 age across wrap", 2, 4);
    pick("R9 wrap remaining", 2, 6);

    cur_time = 16'd100;
    for (int k = 0; k < DEPTH; k++) enq(3, 2, 10 + k, 90 + k);
    enq(3, 2, 30, 80);
    for (int k = 0; k < DEPTH; k++) pick("R10 full drain", 3, 10 + k);
    chk("R10 enqueue when full ignored", int'(sel_valid), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule